// File: doc/BRIEF.md
# One-Time-Programmable Byte Store with Strobe Mode Decode

This block models a one-time-programmable byte memory as it appears on a bus. Three active-low strobes and one flag choose what it does in each cycle. The strobes are chip select, output gate and program pulse. The flag says that programming voltage is present. Depending on them, the block returns a stored byte, keeps its outputs idle, burns a byte into the array, or returns a fixed two-byte identity. A separate identity-select input stands in for the raised voltage that would normally be put on an address line.

Every cell starts erased, reading as all ones. A program cycle can only clear bits: the new cell value is the old value ANDed with the input byte. A bit that has been cleared can never be set to 1 again. The output is a data bus plus a drive-enable flag, and the bus reads 0xFF whenever the flag is low. All inputs are sampled on the rising clock edge. Outputs are registered, so a mode applied before edge k shows on the outputs just after edge k.

Top module: `otp_byte_store`

## Requirements
- R1: After reset, `dout_en` is 0, `dout` is 0xFF, and every cell reads 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_on`=0 and `id_sel`=0, the outputs after the next edge are `dout_en`=1 and `dout` = the addressed cell, whatever `pgm_n` is.
- R3: With `ce_n`=0 and `oe_n`=1 in any case other than R5, the outputs go idle (`dout_en`=0, `dout`=0xFF) and no cell changes.
- R4: With `ce_n`=1, the outputs go idle and no cell changes, whatever `oe_n`, `pgm_n`, `vpp_on` and `id_sel` are.
- R5: With `vpp_on`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0, the addressed cell becomes old AND `din` at the edge, and the outputs go idle.
- R6: No operation sets a cleared bit back to 1. Programming with `din`=0xFF leaves the cell unchanged.
- R7: With `vpp_on`=1, `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `id_sel`=0, the addressed cell is driven. This is program verify, and it shows a byte written on the previous edge.
- R8: With `vpp_on`=1 and `ce_n`, `oe_n` and `pgm_n` all 0, the outputs go idle and no cell changes.
- R9: With `ce_n`=0, `oe_n`=0 and `id_sel`=1, `dout_en`=1 and `dout` is 0x1E when `addr[0]`=0 or 0x86 when `addr[0]`=1. This holds whatever `vpp_on`, `pgm_n` and the upper address bits are, and it takes precedence over R2 and R7.
- R10: `id_sel` has no effect unless `ce_n` and `oe_n` are both 0. In particular, a program cycle with `id_sel`=1 still writes.
- R11: Outputs change only at a clock edge, one edge after the controls that select them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; erases the array |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program pulse, active low |
| vpp_on | input | 1 | Programming voltage present |
| id_sel | input | 1 | Identity readout request |
| din | input | 8 | Byte to program |
| dout | output | 8 | Output data, 0xFF when not driven |
| dout_en | output | 1 | Output drive enable |

## Verification
Two requests can meet in one cycle. The first is identity readout against read or verify, since `id_sel` may be raised while the strobes select a byte read. The bench raises `id_sel` during both read and verify at every address, and expects the identity code rather than the stored byte. The second is a write followed at once by verify of the same address. This checks that the byte driven after edge k+1 already holds the AND of the old cell with the byte programmed at edge k.

// File: rtl/otp_pkg.sv
// Shared definitions for the one-time-programmable byte store.
// Assumes an 8-bit data path; identity codes are fixed constants.
package otp_pkg;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] ERASED   = '1;
    localparam logic [DATA_W-1:0] MFR_CODE = 8'h1E;
    localparam logic [DATA_W-1:0] DEV_CODE = 8'h86;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_INHIBIT,
        M_READ,
        M_DISABLE,
        M_PROGRAM,
        M_VERIFY,
        M_IDENT
    } otp_mode_e;
endpackage

// File: rtl/otp_mode_decode.sv
// Decodes the strobes and the programming flag into one operating mode.
// Assumes all strobes are active low and already synchronous to clk.
// Precedence: chip select, then identity request, then programming.
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      pgm_n,
    input  logic      vpp_on,
    input  logic      id_sel,
    output otp_mode_e mode,
    output logic      wr_en
);
    // Pick the mode from the strobe combination.
    always_comb begin
        if (ce_n)
            mode = vpp_on ? M_INHIBIT : M_STANDBY;
        else if (!oe_n && id_sel)
            mode = M_IDENT;
        else if (oe_n)
            mode = (vpp_on && !pgm_n) ? M_PROGRAM : M_DISABLE;
        else if (!vpp_on)
            mode = M_READ;
        else
            mode = pgm_n ? M_VERIFY : M_DISABLE;
    end

    // Only the program mode may touch the array.
    always_comb wr_en = (mode == M_PROGRAM);
endmodule

// File: rtl/otp_cell_array.sv
// Byte array whose bits can only be cleared; reset puts it in the erased state.
// Assumes one write per cycle; the read port is combinational on addr.
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Erase on reset; on a write, AND the new byte into the word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[g] <= ERASED;
            else if (wr_en && (addr == ADDR_W'(g)))
                cells[g] <= cells[g] & wr_data;
        end
    end

    // Present the addressed word.
    always_comb rd_data = cells[addr];

    // A write followed by a read of the same address shows old AND new.
    assert_and_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($stable(addr) -> rd_data == ($past(rd_data) & $past(wr_data))));
endmodule

// File: rtl/otp_out_stage.sv
// Registered output stage: drives a stored byte, an identity code, or idle.
// Assumes the mode and read data are valid before the clock edge.
module otp_out_stage
    import otp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  otp_mode_e         mode,
    input  logic              id_low_bit,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    // Load the output register from the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= ERASED;
            dout_en <= 1'b0;
        end else begin
            unique case (mode)
                M_READ, M_VERIFY: begin
                    dout    <= rd_data;
                    dout_en <= 1'b1;
                end
                M_IDENT: begin
                    dout    <= id_low_bit ? DEV_CODE : MFR_CODE;
                    dout_en <= 1'b1;
                end
                default: begin
                    dout    <= ERASED;
                    dout_en <= 1'b0;
                end
            endcase
        end
    end

    // A data-carrying mode always leads to a driven output.
    assert_drive_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_READ || mode == M_VERIFY) |=> (dout_en && dout == $past(rd_data)));
endmodule

// File: rtl/otp_byte_store.sv
// Top of the one-time-programmable byte store: mode decode, cell array and output register.
// Assumes synchronous controls; the output is a bus plus drive enable, with idle data 0xFF.
module otp_byte_store
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_on,
    input  logic              id_sel,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    otp_mode_e         mode;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    otp_mode_decode u_decode (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_on (vpp_on),
        .id_sel (id_sel),
        .mode   (mode),
        .wr_en  (wr_en)
    );

    otp_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (din),
        .rd_data (rd_data)
    );

    otp_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .id_low_bit (addr[0]),
        .rd_data    (rd_data),
        .dout       (dout),
        .dout_en    (dout_en)
    );

    // A deselected chip leaves the bus idle.
    assert_standby_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dout_en && dout == 8'hFF));

    // A program pulse never drives the bus.
    assert_program_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && vpp_on && !pgm_n) |=> !dout_en);

    // An identity request returns one of the two codes, chosen by address bit 0.
    assert_ident_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && id_sel) |=>
            (dout_en && dout == ($past(addr[0]) ? 8'h86 : 8'h1E)));

    // Programming voltage with all strobes low must leave the bus idle.
    assert_conflict_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !pgm_n && vpp_on && !id_sel) |=> !dout_en);
endmodule

// File: tb/otp_byte_store_tb.sv
module otp_byte_store_tb;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_on = 1'b0, id_sel = 1'b0;
    logic [7:0]    din = 8'h00;
    logic [7:0]    dout;
    logic          dout_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [N];

    always #2.5 clk = ~clk;

    otp_byte_store #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .pgm_n(pgm_n), .vpp_on(vpp_on), .id_sel(id_sel), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string req, input logic en_x, input logic [7:0] d_x);
        n_chk++;
        if (dout_en !== en_x || dout !== d_x) begin
            n_bad++;
            $display("FAIL %s: got en=%b dout=%h, expected en=%b dout=%h",
                     req, dout_en, dout, en_x, d_x);
        end
    endtask

    // Drive controls after a falling edge, then sample just after the rising edge.
    task automatic cyc(input logic c, input logic o, input logic p, input logic v,
                       input logic i, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; id_sel = i; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic read_all(input string req, input logic v, input logic p);
        for (int a = 0; a < N; a++) begin
            cyc(1'b0, 1'b0, p, v, 1'b0, AW'(a), 8'h00);
            check(req, 1'b1, model[a]);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        for (int a = 0; a < N; a++) model[a] = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", 1'b0, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;
        read_all("R1 erased array", 1'b0, 1'b1);

        // R11: controls applied at the falling edge do not show before the rising edge.
        @(negedge clk);
        ce_n = 1'b1;
        #1;
        check("R11 no change before edge", 1'b1, model[N-1]);
        @(posedge clk);
        #1;
        check("R11 change after edge", 1'b0, 8'hFF);

        // R5 / R7: program each address, then verify it on the next cycle.
        for (int a = 0; a < N; a++) begin
            logic [7:0] p;
            p = 8'((a * 37 + 5) & 8'hFF);
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(a), p);
            check("R5 program idle", 1'b0, 8'hFF);
            model[a] = model[a] & p;
            cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(a), 8'h00);
            check("R7 verify after write", 1'b1, model[a]);
        end
        read_all("R2 read pgm_n high", 1'b0, 1'b1);

        // R6: a second pattern can only clear further bits.
        for (int a = 0; a < N; a++) begin
            logic [7:0] q;
            q = ~8'((a * 11) & 8'hFF);
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(a), q);
            model[a] = model[a] & q;
        end
        read_all("R6 and-only reprogram / R2 pgm_n low", 1'b0, 1'b0);
        for (int a = 0; a < N; a++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(a), 8'hFF);
        read_all("R6 all-ones write keeps cell", 1'b0, 1'b1);

        // R4: deselected, every control combination, din zero: idle, no write.
        for (int k = 0; k < 16; k++) begin
            cyc(1'b1, k[0], k[1], k[2], k[3], AW'(k), 8'h00);
            check("R4 deselected idle", 1'b0, 8'hFF);
        end
        // R3: output gate high without a program pulse.
        for (int a = 0; a < N; a++) begin
            cyc(1'b0, 1'b1, a[0], 1'b0, a[1], AW'(a), 8'h00);
            check("R3 output disabled", 1'b0, 8'hFF);
            cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(a), 8'h00);
            check("R3 vpp without pulse", 1'b0, 8'hFF);
        end
        // R8: all strobes low with programming voltage.
        for (int a = 0; a < N; a++) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, AW'(a), 8'h00);
            check("R8 conflicting strobes idle", 1'b0, 8'hFF);
        end
        read_all("R3 R4 R8 no write occurred", 1'b0, 1'b1);

        // R9: identity codes override read and verify at every address.
        for (int a = 0; a < N; a++) begin
            for (int m = 0; m < 3; m++) begin
                cyc(1'b0, 1'b0, m != 1, m != 0, 1'b1, AW'(a), 8'h00);
                check("R9 identity code", 1'b1, a[0] ? 8'h86 : 8'h1E);
            end
        end

        // R10: identity request during a program pulse still writes.
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, AW'(3), 8'h0F);
        check("R10 id_sel in program idle", 1'b0, 8'hFF);
        model[3] = model[3] & 8'h0F;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(3), 8'h00);
        check("R10 write with id_sel took effect", 1'b1, model[3]);

        // R1: reset again erases everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset idle again", 1'b0, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < N; a++) model[a] = 8'hFF;
        read_all("R1 erased after reset", 1'b0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule